// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial slave port of a page-erasable flash device. It oversamples chip select, serial clock and serial data in with the device clock, puts together an instruction byte, a three-byte address and any payload bytes, and passes the decoded result to the device core. Payload bytes for page programming go out as per-byte write strobes. The finished command goes out as one execute strobe when chip select is released. Status bytes and array bytes are shifted out on the serial data output. That output is enabled only while a read-type command is in its output phase.

The block also decides, at the rising edge of chip select, whether a modifying command may run. The command must have been framed in whole bytes and must be complete. The block must have seen a chip select falling edge since reset. The block must not be in deep power-down. It also reports the power mode: standby, active, or deep power-down. The memory array, the program and erase timing, the write-enable latch and the protection rules belong to the core. The core supplies a status byte and a busy flag, and it answers array read requests with a one-byte grant.

Top module: `spi_flash_frontend`

## Requirements
- R1: While reset is asserted, the data output enable is low, `pwr_mode_o` reads 0 (standby), and no strobe is raised.
- R2: No instruction takes effect until a falling edge of chip select has been seen after reset. A command clocked in while chip select has stayed low since reset produces no execute strobe.
- R3: `spi_miso_oe` is low whenever chip select has been high for four or more device clocks. It goes high only inside the output phase of a status or read command.
- R4: The read-status instruction (05h) returns the core status byte again for every byte clocked while chip select stays low. Each byte is captured live, so a change of status between bytes is visible.
- R5: The read instruction (03h) takes a 24-bit address, most significant byte first. It then returns the array byte at that address, followed by the bytes at consecutive addresses, with carries across byte boundaries, for as long as chip select stays low.
- R6: The fast-read instruction (0Bh) ignores one dummy byte after the address, then behaves as in R5.
- R7: For page write (0Ah) and page program (02h), each payload byte raises `wr_stb_o` for one clock with its data. The page column (address bits 7..0) starts at the given address and wraps from FFh to 00h. The upper address bits do not change.
- R8: A modifying command raises `exec_stb_o` for one clock at the rising edge of chip select, and only then. The bit count since the falling edge must be a multiple of eight. Page erase (DBh) and sector erase (D8h) need the full address. Page write and page program need at least one payload byte. `exec_addr_o` carries the start address.
- R9: Write enable (06h) and write disable (04h) raise `exec_stb_o` with `exec_cmd_o` 1 and 2 respectively. The other codes are 3 page write, 4 page program, 5 page erase and 6 sector erase.
- R10: After deep power-down (B9h) completes, `pwr_mode_o` reads 2. Every instruction except release (ABh) is then ignored: no execute strobe and no driven output. Release returns the block to normal operation.
- R11: `pwr_mode_o` reads 1 (active) while the block is selected or the core is busy, and 0 (standby) otherwise. Deep power-down takes precedence over both.
- R12: Clock mode 3 (clock idles high) gives the same results as mode 0. Bits are sampled on rising edges, and the output changes after falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, at least eight times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| status_i | input | 8 | Status byte supplied by the core |
| busy_i | input | 1 | Core internal cycle in progress |
| rd_req_o | output | 1 | One-clock request for the array byte at `rd_addr_o` |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_gnt_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| wr_stb_o | output | 1 | Payload byte strobe |
| wr_addr_o | output | ADDR_W | Payload byte address |
| wr_data_o | output | 8 | Payload byte |
| exec_stb_o | output | 1 | Command execute strobe |
| exec_cmd_o | output | 3 | Executed command code (R9) |
| exec_addr_o | output | ADDR_W | Command start address |
| pwr_mode_o | output | 2 | 0 standby, 1 active, 2 deep power-down |

## Verification
The checker watches four things on every clock. The output enable stays off while the block is deselected. The read, write and execute strobes never coincide. An execute strobe lasts exactly one clock and never appears in deep power-down. A busy core forces the active power mode. Other properties need whole serial transactions, so only the bench scenarios can show them: the returned status and array bytes, the column wrap in page programming, rejection of commands with a partial byte or a missing address or payload, the first-falling-edge rule after reset, and mode 3 behaving like mode 0.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

   typedef enum logic [3:0] {
      C_NONE, C_WREN, C_WRDI, C_RDSR, C_READ, C_FREAD,
      C_PW, C_PP, C_PE, C_SE, C_DP, C_RDP
   } cmd_e;

   typedef enum logic [2:0] {
      PH_OPC, PH_ADDR, PH_DUMMY, PH_DIN, PH_DOUT, PH_SKIP
   } phase_e;

   typedef enum logic [1:0] {
      PM_STANDBY = 2'd0,
      PM_ACTIVE  = 2'd1,
      PM_DEEP    = 2'd2
   } pmode_e;

   localparam logic [2:0] EX_WREN = 3'd1;
   localparam logic [2:0] EX_WRDI = 3'd2;
   localparam logic [2:0] EX_PW   = 3'd3;
   localparam logic [2:0] EX_PP   = 3'd4;
   localparam logic [2:0] EX_PE   = 3'd5;
   localparam logic [2:0] EX_SE   = 3'd6;

endpackage

// File: rtl/sfe_pin_sync.sv
module sfe_pin_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sfe_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfe_rx_shift.sv
module sfe_rx_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       sck_rise,
   input  logic       mosi,
   output logic       byte_stb_o,
   output logic [7:0] byte_o,
   output logic       aligned_o
);
   logic [2:0] bit_cnt;
   logic [6:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         sh         <= '0;
         byte_stb_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         byte_stb_o <= 1'b0;
         if (!sel) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            sh      <= {sh[5:0], mosi};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_stb_o <= 1'b1;
               byte_o     <= {sh, mosi};
            end
         end
      end
   end

   assign aligned_o = (bit_cnt == 3'd0);
endmodule

// File: rtl/sfe_tx_shift.sv
module sfe_tx_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       sck_fall,
   input  logic       active,
   input  logic [7:0] next_byte_i,
   output logic       take_o,
   output logic       miso_o,
   output logic       oe_o
);
   logic [2:0] cnt;
   logic [7:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sh     <= '0;
         take_o <= 1'b0;
         oe_o   <= 1'b0;
      end else begin
         take_o <= 1'b0;
         if (!sel) begin
            cnt  <= '0;
            oe_o <= 1'b0;
         end else if (sck_fall && active) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd0) begin
               sh     <= next_byte_i;
               take_o <= 1'b1;
               oe_o   <= 1'b1;
            end else begin
               sh <= {sh[6:0], 1'b0};
            end
         end
      end
   end

   assign miso_o = sh[7];
endmodule

// File: rtl/sfe_cmd_ctrl.sv
module sfe_cmd_ctrl
   import sfe_pkg::*;
#(
   parameter int         ADDR_W      = 24,
   parameter int         PAGE_W      = 8,
   parameter int         DUMMY_BYTES = 1,
   parameter logic [7:0] OP_WREN     = 8'h06,
   parameter logic [7:0] OP_WRDI     = 8'h04,
   parameter logic [7:0] OP_RDSR     = 8'h05,
   parameter logic [7:0] OP_READ     = 8'h03,
   parameter logic [7:0] OP_FREAD    = 8'h0B,
   parameter logic [7:0] OP_PW       = 8'h0A,
   parameter logic [7:0] OP_PP       = 8'h02,
   parameter logic [7:0] OP_PE       = 8'hDB,
   parameter logic [7:0] OP_SE       = 8'hD8,
   parameter logic [7:0] OP_DP       = 8'hB9,
   parameter logic [7:0] OP_RDP      = 8'hAB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              byte_stb,
   input  logic [7:0]        byte_in,
   input  logic              aligned,
   input  logic              take,
   input  logic [7:0]        status_i,
   input  logic              busy_i,
   input  logic              rd_gnt_i,
   input  logic [7:0]        rd_data_i,
   output logic              out_active,
   output logic [7:0]        next_byte,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              exec_stb_o,
   output logic [2:0]        exec_cmd_o,
   output logic [ADDR_W-1:0] exec_addr_o,
   output logic [1:0]        pwr_mode_o
);
   localparam int ABYTES = ADDR_W / 8;
   localparam int ACNT_W = $clog2(ABYTES + 1);
   localparam int DCNT_W = (DUMMY_BYTES > 1) ? $clog2(DUMMY_BYTES) : 1;
   localparam logic [ACNT_W-1:0] ALAST = ACNT_W'(ABYTES - 1);
   localparam logic [DCNT_W-1:0] DLAST = DCNT_W'((DUMMY_BYTES > 0) ? DUMMY_BYTES - 1 : 0);

   logic              armed, dpd, ready, buf_v, req_pend;
   phase_e            phase;
   cmd_e              cmd, dec;
   pmode_e            pmode;
   logic [ACNT_W-1:0] acnt;
   logic [DCNT_W-1:0] dcnt;
   logic [ADDR_W-1:0] addr, addr_next;
   logic [PAGE_W-1:0] col;
   logic [7:0]        rbuf;
   logic              is_read;

   // opcode decode; in deep power-down only release is recognised
   always_comb begin
      dec = C_NONE;
      if (byte_in == OP_RDP)                    dec = C_RDP;
      else if (dpd)                             dec = C_NONE;
      else if (byte_in == OP_WREN)              dec = C_WREN;
      else if (byte_in == OP_WRDI)              dec = C_WRDI;
      else if (byte_in == OP_RDSR)              dec = C_RDSR;
      else if (byte_in == OP_READ)              dec = C_READ;
      else if (byte_in == OP_FREAD)             dec = C_FREAD;
      else if (byte_in == OP_PW)                dec = C_PW;
      else if (byte_in == OP_PP)                dec = C_PP;
      else if (byte_in == OP_PE)                dec = C_PE;
      else if (byte_in == OP_SE)                dec = C_SE;
      else if (byte_in == OP_DP)                dec = C_DP;
   end

   assign addr_next = {addr[ADDR_W-9:0], byte_in};
   assign is_read   = (cmd == C_READ) || (cmd == C_FREAD);

   function automatic logic [2:0] exec_code(cmd_e c);
      case (c)
         C_WREN:  return EX_WREN;
         C_WRDI:  return EX_WRDI;
         C_PW:    return EX_PW;
         C_PP:    return EX_PP;
         C_PE:    return EX_PE;
         C_SE:    return EX_SE;
         default: return 3'd0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         dpd         <= 1'b0;
         ready       <= 1'b0;
         buf_v       <= 1'b0;
         req_pend    <= 1'b0;
         phase       <= PH_OPC;
         cmd         <= C_NONE;
         acnt        <= '0;
         dcnt        <= '0;
         addr        <= '0;
         col         <= '0;
         rbuf        <= '0;
         rd_req_o    <= 1'b0;
         wr_stb_o    <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         exec_stb_o  <= 1'b0;
         exec_cmd_o  <= '0;
         exec_addr_o <= '0;
      end else begin
         rd_req_o   <= 1'b0;
         wr_stb_o   <= 1'b0;
         exec_stb_o <= 1'b0;

         if (cs_fall) armed <= 1'b1;

         if (!sel) begin
            phase    <= PH_OPC;
            acnt     <= '0;
            dcnt     <= '0;
            ready    <= 1'b0;
            buf_v    <= 1'b0;
            req_pend <= 1'b0;
         end

         // acceptance at deselect: whole bytes and a complete frame
         if (cs_rise && armed && aligned && ready) begin
            case (cmd)
               C_DP:  dpd <= 1'b1;
               C_RDP: dpd <= 1'b0;
               C_WREN, C_WRDI, C_PW, C_PP, C_PE, C_SE: begin
                  exec_stb_o  <= 1'b1;
                  exec_cmd_o  <= exec_code(cmd);
                  exec_addr_o <= addr;
               end
               default: ;
            endcase
         end

         if (sel && byte_stb) begin
            case (phase)
               PH_OPC: begin
                  cmd <= dec;
                  if (!armed) phase <= PH_SKIP;
                  else begin
                     case (dec)
                        C_WREN, C_WRDI, C_DP, C_RDP: begin
                           ready <= 1'b1;
                           phase <= PH_SKIP;
                        end
                        C_RDSR: phase <= PH_DOUT;
                        C_READ, C_FREAD, C_PW, C_PP, C_PE, C_SE: phase <= PH_ADDR;
                        default: phase <= PH_SKIP;
                     endcase
                  end
               end
               PH_ADDR: begin
                  addr <= addr_next;
                  acnt <= acnt + 1'b1;
                  if (acnt == ALAST) begin
                     col <= addr_next[PAGE_W-1:0];
                     case (cmd)
                        C_READ:  phase <= PH_DOUT;
                        C_FREAD: phase <= (DUMMY_BYTES > 0) ? PH_DUMMY : PH_DOUT;
                        C_PW, C_PP: phase <= PH_DIN;
                        default: begin
                           ready <= 1'b1;
                           phase <= PH_SKIP;
                        end
                     endcase
                  end
               end
               PH_DUMMY: begin
                  dcnt <= dcnt + 1'b1;
                  if (dcnt == DLAST) phase <= PH_DOUT;
               end
               PH_DIN: begin
                  wr_stb_o  <= 1'b1;
                  wr_addr_o <= {addr[ADDR_W-1:PAGE_W], col};
                  wr_data_o <= byte_in;
                  col       <= col + 1'b1;
                  ready     <= 1'b1;
               end
               default: ;
            endcase
         end

         // array read prefetch: one byte held ahead of the shifter
         if (sel && phase == PH_DOUT && is_read) begin
            if (take) buf_v <= 1'b0;
            if (!buf_v && !req_pend && !take) begin
               rd_req_o <= 1'b1;
               req_pend <= 1'b1;
            end
            if (req_pend && rd_gnt_i) begin
               rbuf     <= rd_data_i;
               buf_v    <= 1'b1;
               req_pend <= 1'b0;
               addr     <= addr + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pmode <= PM_STANDBY;
      else if (dpd) pmode <= PM_DEEP;
      else if (sel || busy_i) pmode <= PM_ACTIVE;
      else pmode <= PM_STANDBY;
   end

   assign pwr_mode_o = pmode;
   assign out_active = (phase == PH_DOUT);
   assign next_byte  = (cmd == C_RDSR) ? status_i : rbuf;
   assign rd_addr_o  = addr;
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
   parameter int         ADDR_W      = 24,
   parameter int         PAGE_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         DUMMY_BYTES = 1,
   parameter logic [7:0] OP_WREN     = 8'h06,
   parameter logic [7:0] OP_WRDI     = 8'h04,
   parameter logic [7:0] OP_RDSR     = 8'h05,
   parameter logic [7:0] OP_READ     = 8'h03,
   parameter logic [7:0] OP_FREAD    = 8'h0B,
   parameter logic [7:0] OP_PW       = 8'h0A,
   parameter logic [7:0] OP_PP       = 8'h02,
   parameter logic [7:0] OP_PE       = 8'hDB,
   parameter logic [7:0] OP_SE       = 8'hD8,
   parameter logic [7:0] OP_DP       = 8'hB9,
   parameter logic [7:0] OP_RDP      = 8'hAB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic [7:0]        status_i,
   input  logic              busy_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_gnt_i,
   input  logic [7:0]        rd_data_i,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              exec_stb_o,
   output logic [2:0]        exec_cmd_o,
   output logic [ADDR_W-1:0] exec_addr_o,
   output logic [1:0]        pwr_mode_o
);
   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_aw
         $error("spi_flash_frontend: ADDR_W must be a multiple of 8, at least 16");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_pw
         $error("spi_flash_frontend: PAGE_W must lie in 1..ADDR_W-1");
      end
      if (DUMMY_BYTES < 0) begin : g_bad_dummy
         $error("spi_flash_frontend: DUMMY_BYTES must not be negative");
      end
   endgenerate

   // pins synchronised with chip select reset to 0 so that a select
   // held since reset never produces a falling edge
   logic [2:0] pins_s;
   logic       cs_n_q, sck_q;

   sfe_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sck, spi_mosi}),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q <= 1'b0;
         sck_q  <= 1'b0;
      end else begin
         cs_n_q <= pins_s[2];
         sck_q  <= pins_s[1];
      end
   end

   logic sel, cs_fall, cs_rise, sck_rise, sck_fall;
   assign sel      = !pins_s[2];
   assign cs_fall  = !pins_s[2] &&  cs_n_q;
   assign cs_rise  =  pins_s[2] && !cs_n_q;
   assign sck_rise =  pins_s[1] && !sck_q;
   assign sck_fall = !pins_s[1] &&  sck_q;

   logic       byte_stb, aligned, take, out_active;
   logic [7:0] byte_rx, next_byte;

   sfe_rx_shift u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .sck_rise   (sck_rise),
      .mosi       (pins_s[0]),
      .byte_stb_o (byte_stb),
      .byte_o     (byte_rx),
      .aligned_o  (aligned)
   );

   sfe_tx_shift u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (sel),
      .sck_fall    (sck_fall),
      .active      (out_active),
      .next_byte_i (next_byte),
      .take_o      (take),
      .miso_o      (spi_miso),
      .oe_o        (spi_miso_oe)
   );

   sfe_cmd_ctrl #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DUMMY_BYTES(DUMMY_BYTES),
      .OP_WREN(OP_WREN), .OP_WRDI(OP_WRDI), .OP_RDSR(OP_RDSR),
      .OP_READ(OP_READ), .OP_FREAD(OP_FREAD), .OP_PW(OP_PW), .OP_PP(OP_PP),
      .OP_PE(OP_PE), .OP_SE(OP_SE), .OP_DP(OP_DP), .OP_RDP(OP_RDP)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (sel),
      .cs_fall     (cs_fall),
      .cs_rise     (cs_rise),
      .byte_stb    (byte_stb),
      .byte_in     (byte_rx),
      .aligned     (aligned),
      .take        (take),
      .status_i    (status_i),
      .busy_i      (busy_i),
      .rd_gnt_i    (rd_gnt_i),
      .rd_data_i   (rd_data_i),
      .out_active  (out_active),
      .next_byte   (next_byte),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .wr_stb_o    (wr_stb_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o),
      .exec_stb_o  (exec_stb_o),
      .exec_cmd_o  (exec_cmd_o),
      .exec_addr_o (exec_addr_o),
      .pwr_mode_o  (pwr_mode_o)
   );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_miso_oe,
   input logic       busy_i,
   input logic       rd_req_o,
   input logic       wr_stb_o,
   input logic       exec_stb_o,
   input logic [1:0] pwr_mode_o
);
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!spi_miso_oe && pwr_mode_o == 2'd0 && !exec_stb_o && !wr_stb_o && !rd_req_o));

   p_oe_off_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> !spi_miso_oe);

   p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req_o, wr_stb_o, exec_stb_o}));

   p_exec_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb_o |=> !exec_stb_o);

   p_no_exec_deep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb_o |-> $past(pwr_mode_o) != 2'd2);

   p_busy_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(busy_i) && pwr_mode_o != 2'd2) |-> pwr_mode_o == 2'd1);
endmodule

bind spi_flash_frontend sfe_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_cs_n    (spi_cs_n),
   .spi_miso_oe (spi_miso_oe),
   .busy_i      (busy_i),
   .rd_req_o    (rd_req_o),
   .wr_stb_o    (wr_stb_o),
   .exec_stb_o  (exec_stb_o),
   .pwr_mode_o  (pwr_mode_o)
);

// File: tb/sim_spi_flash_frontend.sv
module sim_spi_flash_frontend;
   localparam int HALF = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
   logic        rd_gnt = 1'b0;
   logic [7:0]  status = 8'h00, rd_data = 8'h00;
   logic        miso, miso_oe, rd_req, wr_stb, exec_stb;
   logic [23:0] rd_addr, wr_addr, exec_addr;
   logic [7:0]  wr_data;
   logic [2:0]  exec_cmd;
   logic [1:0]  pwr;

   spi_flash_frontend u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .status_i(status), .busy_i(busy),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt), .rd_data_i(rd_data),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .exec_stb_o(exec_stb), .exec_cmd_o(exec_cmd), .exec_addr_o(exec_addr),
      .pwr_mode_o(pwr)
   );

   int          checks = 0, errors = 0;
   bit          m3 = 1'b0;
   int          n_exec = 0, n_wr = 0, n_strobe = 0;
   logic [2:0]  last_cmd = '0;
   logic [23:0] last_eaddr = '0;
   logic [23:0] wr_a [8];
   logic [7:0]  wr_d [8];
   bit          oe_seen = 1'b0;

   function automatic logic [7:0] model(logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   // core model: records strobes, answers read requests one clock later
   always @(negedge clk) begin
      if (exec_stb) begin
         n_exec++;
         last_cmd   = exec_cmd;
         last_eaddr = exec_addr;
      end
      if (wr_stb) begin
         if (n_wr < 8) begin
            wr_a[n_wr] = wr_addr;
            wr_d[n_wr] = wr_data;
         end
         n_wr++;
      end
      if (exec_stb || wr_stb || rd_req) n_strobe++;
      if (miso_oe) oe_seen = 1'b1;
      if (rd_req) begin
         rd_gnt  = 1'b1;
         rd_data = model(rd_addr);
      end else begin
         rd_gnt = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_low();
      @(negedge clk);
      sck  = m3;
      waitc(2);
      cs_n = 1'b0;
      waitc(HALF);
   endtask

   task automatic cs_high();
      waitc(HALF);
      cs_n = 1'b1;
      waitc(3 * HALF);
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         @(negedge clk);
         if (m3) sck = 1'b0;
         mosi = tx[i];
         waitc(HALF);
         rx[i] = miso;
         sck = 1'b1;
         waitc(HALF);
         if (!m3) sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] dummy;
      xfer(tx, dummy);
   endtask

   task automatic send_addr(input logic [23:0] a);
      send(a[23:16]);
      send(a[15:8]);
      send(a[7:0]);
   endtask

   // ---------------------------------------------------------------
   task automatic t_reset();
      waitc(3);
      chk(miso_oe == 1'b0, "R1 oe in reset", miso_oe, 0);
      chk(pwr == 2'd0, "R1 pwr in reset", pwr, 0);
      chk(n_strobe == 0, "R1 strobes in reset", n_strobe, 0);
   endtask

   task automatic t_unarmed();
      int e0;
      e0 = n_exec;
      send(8'h06);
      cs_high();
      chk(n_exec == e0, "R2 command before first select edge", n_exec - e0, 0);
   endtask

   task automatic t_wren_wrdi();
      int e0;
      e0 = n_exec;
      cs_low();
      chk(pwr == 2'd1, "R11 active while selected", pwr, 1);
      send(8'h06);
      cs_high();
      chk(n_exec == e0 + 1 && last_cmd == 3'd1, "R9 write enable exec", {n_exec - e0, 1'b0, last_cmd}, {32'd1, 1'b0, 3'd1});
      chk(pwr == 2'd0, "R11 standby after deselect", pwr, 0);
      cs_low();
      send(8'h04);
      cs_high();
      chk(n_exec == e0 + 2 && last_cmd == 3'd2, "R9 write disable exec", last_cmd, 2);
   endtask

   task automatic t_framing();
      int e0;
      logic [7:0] r;
      e0 = n_exec;
      cs_low();
      send(8'hDB);
      send_addr(24'h012345);
      xfer_bits(8'hFF, 3, r);
      cs_high();
      chk(n_exec == e0, "R8 partial byte rejects erase", n_exec - e0, 0);
      cs_low();
      send(8'hD8);
      send(8'h01);
      send(8'h23);
      cs_high();
      chk(n_exec == e0, "R8 short address rejects erase", n_exec - e0, 0);
      cs_low();
      send(8'h0A);
      send_addr(24'h000300);
      cs_high();
      chk(n_exec == e0, "R8 page write without payload rejected", n_exec - e0, 0);
      cs_low();
      send(8'hDB);
      send_addr(24'h012345);
      cs_high();
      chk(n_exec == e0 + 1 && last_cmd == 3'd5 && last_eaddr == 24'h012345,
          "R8 whole-byte page erase", {5'd0, last_cmd, last_eaddr}, {5'd0, 3'd5, 24'h012345});
      cs_low();
      send(8'hD8);
      send_addr(24'h020000);
      cs_high();
      chk(n_exec == e0 + 2 && last_cmd == 3'd6, "R8 sector erase code", last_cmd, 6);
   endtask

   task automatic t_status(input string tag);
      logic [7:0] r;
      oe_seen = 1'b0;
      status = 8'h03;
      cs_low();
      send(8'h05);
      xfer(8'h00, r);
      chk(r == 8'h03, {tag, " status byte 1"}, r, 8'h03);
      chk(miso_oe == 1'b1, {"R3 oe in status output ", tag}, miso_oe, 1);
      xfer(8'h00, r);
      chk(r == 8'h03, {tag, " status byte 2 repeats"}, r, 8'h03);
      status = 8'h02;
      xfer(8'h00, r);
      chk(r == 8'h02, {tag, " status change seen live"}, r, 8'h02);
      cs_high();
      chk(miso_oe == 1'b0, {"R3 oe off after deselect ", tag}, miso_oe, 0);
      status = 8'h00;
   endtask

   task automatic t_read(input logic [7:0] opc, input int dummies, input logic [23:0] a, input string tag);
      logic [7:0] r;
      cs_low();
      send(opc);
      send_addr(a);
      for (int d = 0; d < dummies; d++) send(8'h00);
      for (int i = 0; i < 4; i++) begin
         xfer(8'h00, r);
         chk(r == model(a + 24'(i)), {tag, " read byte"}, {a + 24'(i), r}, {a + 24'(i), model(a + 24'(i))});
      end
      cs_high();
   endtask

   task automatic t_program(input string tag);
      int e0, w0;
      e0 = n_exec;
      w0 = n_wr;
      n_wr = 0;
      cs_low();
      send(8'h02);
      send_addr(24'h0005FE);
      send(8'hA1);
      send(8'hB2);
      send(8'hC3);
      send(8'hD4);
      cs_high();
      chk(n_wr == 4, {tag, " payload strobes"}, n_wr, 4);
      chk(wr_a[0] == 24'h0005FE && wr_d[0] == 8'hA1, {tag, " first byte"}, {wr_a[0], wr_d[0]}, {24'h0005FE, 8'hA1});
      chk(wr_a[2] == 24'h000500 && wr_d[2] == 8'hC3, {tag, " column wraps in page"}, {wr_a[2], wr_d[2]}, {24'h000500, 8'hC3});
      chk(wr_a[3] == 24'h000501, {tag, " column after wrap"}, wr_a[3], 24'h000501);
      chk(n_exec == e0 + 1 && last_cmd == 3'd4 && last_eaddr == 24'h0005FE,
          "R8 page program exec", {5'd0, last_cmd, last_eaddr}, {5'd0, 3'd4, 24'h0005FE});
      if (w0 < 0) n_wr = w0;
   endtask

   task automatic t_deep();
      int e0;
      logic [7:0] r;
      e0 = n_exec;
      cs_low();
      send(8'hB9);
      cs_high();
      chk(pwr == 2'd2, "R10 deep power-down entered", pwr, 2);
      cs_low();
      chk(pwr == 2'd2, "R10 deep mode kept while selected", pwr, 2);
      send(8'h06);
      cs_high();
      cs_low();
      send(8'hDB);
      send_addr(24'h000100);
      cs_high();
      chk(n_exec == e0, "R10 commands ignored in deep mode", n_exec - e0, 0);
      oe_seen = 1'b0;
      status = 8'h81;
      cs_low();
      send(8'h05);
      xfer(8'h00, r);
      cs_high();
      chk(oe_seen == 1'b0, "R10 no output in deep mode", oe_seen, 0);
      cs_low();
      send(8'hAB);
      cs_high();
      chk(pwr == 2'd0, "R10 release to standby", pwr, 0);
      cs_low();
      send(8'h06);
      cs_high();
      chk(n_exec == e0 + 1 && last_cmd == 3'd1, "R10 commands accepted after release", n_exec - e0, 1);
      status = 8'h00;
   endtask

   task automatic t_busy();
      busy = 1'b1;
      waitc(4);
      chk(pwr == 2'd1, "R11 active while core busy and deselected", pwr, 1);
      busy = 1'b0;
      waitc(4);
      chk(pwr == 2'd0, "R11 standby once busy clears", pwr, 0);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      waitc(4);
      t_unarmed();
      t_wren_wrdi();
      t_framing();
      t_status("R4");
      t_read(8'h03, 0, 24'h0123FE, "R5");
      t_read(8'h0B, 1, 24'h00A0FF, "R6");
      t_program("R7");
      t_deep();
      t_busy();
      m3 = 1'b1;
      t_status("R12 mode3 R4");
      t_read(8'h03, 0, 24'h3400FD, "R12 mode3 R5");
      t_program("R12 mode3 R7");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule